// File: doc/BRIEF.md
# Receiver Error Flag Aggregator

This block gathers the individual error conditions reported by a digital audio (AES3) receiver and folds them into a single error output. Six of the conditions are produced by the frame decoder once per subframe and arrive with a subframe strobe. They are validity, parity, bi-phase coding, confidence, Q-subcode CRC and channel-status CRC. The seventh, PLL loss of lock, is a level that may change at any time. It is resynchronised and followed continuously, so a receiver that has lost lock and delivers no subframes still reports the fault.

A seven-bit enable mask, loaded through a simple write port, chooses which conditions may drive the output. A mask bit of 1 lets its source through. The mask clears to zero on reset, so every source starts blocked. The error output has no memory. It is high in exactly the cycles where some enabled source is currently flagged, and it drops as soon as the last enabled source clears, with no read or acknowledge. The unmasked state of all seven sources is presented at the same time on a raw status output.

Top module: `rx_err_agg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `raw_status` and `rx_err` are 0 and the enable mask is all zeros. With the mask still at zero, no flagged source raises `rx_err`.
- R2: On a clock edge with `sf_strobe` high, `sf_flags` is captured into `raw_status[5:0]`, and it is visible from the next cycle. The bit positions are: 0 validity, 1 parity, 2 bi-phase coding, 3 confidence, 4 Q-subcode CRC, 5 channel-status CRC.
- R3: On edges without `sf_strobe`, `raw_status[5:0]` keeps its value whatever `sf_flags` carries.
- R4: `raw_status[6]` follows `pll_unlock` after `SYNC_STAGES` clock edges (2 by default), whether or not subframes arrive.
- R5: On an edge with `mask_we` high, the enable mask takes `mask_wdata`. Bit i enables the source at `raw_status` bit i.
- R6: `rx_err` is high in the same cycle in which any source that is both flagged in `raw_status` and enabled in the mask shows up. There is no extra delay.
- R7: `rx_err` falls in the same cycle in which the last enabled flagged source clears. Nothing is latched.
- R8: A source whose mask bit is 0 never raises `rx_err`.
- R9: A mask write and a subframe capture on the same edge both take effect together. `rx_err` in the next cycle reflects the new flags under the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_strobe | input | 1 | One-cycle pulse marking a decoded subframe |
| sf_flags | input | 6 | Per-subframe error flags, sampled on `sf_strobe` |
| pll_unlock | input | 1 | PLL loss-of-lock level, asynchronous |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | 7 | New enable mask value |
| raw_status | output | 7 | Unmasked current state of all seven sources |
| rx_err | output | 1 | Aggregated error flag |

## Verification
A mask write and a subframe capture can land on the same clock edge, and so can a change of the resynchronised lock flag. The error output must then be computed from the new flags under the new mask, not from a mix of old and new. Directed steps provoke this. In one step, a flag and its enable bit arrive on the same edge. In another, the enable bit is removed on the same edge as a flag rises. The random phase drives strobe, write and lock changes with independent probabilities, so the three collide often. After every edge a bench model, which applies all updates of that edge together, judges `rx_err` and `raw_status`.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int NUM_FRAMED = 6;
  localparam int NUM_SRC    = NUM_FRAMED + 1;

  localparam int SRC_VALIDITY = 0;
  localparam int SRC_PARITY   = 1;
  localparam int SRC_BIPHASE  = 2;
  localparam int SRC_CONFID   = 3;
  localparam int SRC_QCRC     = 4;
  localparam int SRC_CSCRC    = 5;
  localparam int SRC_UNLOCK   = 6;

  typedef logic [NUM_SRC-1:0]    src_vec_t;
  typedef logic [NUM_FRAMED-1:0] framed_vec_t;
endpackage

// File: rtl/rx_err_capture.sv
module rx_err_capture
  import rx_err_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sf_strobe,
  input  framed_vec_t sf_flags,
  input  logic        pll_unlock,
  output framed_vec_t framed_d,
  output framed_vec_t framed_q,
  output logic        unlock_d,
  output logic        unlock_q
);
  framed_vec_t             framed_r;
  logic [SYNC_STAGES-1:0]  chain_r;
  logic [SYNC_STAGES-1:0]  chain_n;

  assign framed_d = sf_strobe ? sf_flags : framed_r;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign chain_n = pll_unlock;
    end else begin : g_multi
      assign chain_n = {chain_r[SYNC_STAGES-2:0], pll_unlock};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      framed_r <= '0;
      chain_r  <= '0;
    end else begin
      framed_r <= framed_d;
      chain_r  <= chain_n;
    end
  end

  assign framed_q = framed_r;
  assign unlock_d = chain_n[SYNC_STAGES-1];
  assign unlock_q = chain_r[SYNC_STAGES-1];
endmodule

// File: rtl/rx_err_mask.sv
module rx_err_mask
  import rx_err_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mask_we,
  input  src_vec_t mask_wdata,
  output src_vec_t mask_d,
  output src_vec_t mask_q
);
  src_vec_t mask_r;

  assign mask_d = mask_we ? mask_wdata : mask_r;

  always_ff @(posedge clk) begin
    if (rst) mask_r <= '0;
    else     mask_r <= mask_d;
  end

  assign mask_q = mask_r;
endmodule

// File: rtl/rx_err_combine.sv
module rx_err_combine
  import rx_err_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t raw_next,
  input  src_vec_t mask_next,
  output logic     err_q
);
  src_vec_t gated;
  logic     err_r;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign gated[i] = raw_next[i] & mask_next[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) err_r <= 1'b0;
    else     err_r <= |gated;
  end

  assign err_q = err_r;
endmodule

// File: rtl/rx_err_agg.sv
module rx_err_agg
  import rx_err_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sf_strobe,
  input  logic [NUM_FRAMED-1:0] sf_flags,
  input  logic                  pll_unlock,
  input  logic                  mask_we,
  input  logic [NUM_SRC-1:0]    mask_wdata,
  output logic [NUM_SRC-1:0]    raw_status,
  output logic                  rx_err
);
  framed_vec_t framed_d, framed_q;
  logic        unlock_d, unlock_q;
  src_vec_t    mask_d, mask_q;
  src_vec_t    raw_next;

  rx_err_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .sf_strobe (sf_strobe),
    .sf_flags  (sf_flags),
    .pll_unlock(pll_unlock),
    .framed_d  (framed_d),
    .framed_q  (framed_q),
    .unlock_d  (unlock_d),
    .unlock_q  (unlock_q)
  );

  rx_err_mask u_mask (
    .clk       (clk),
    .rst       (rst),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .mask_d    (mask_d),
    .mask_q    (mask_q)
  );

  assign raw_next = {unlock_d, framed_d};

  rx_err_combine u_combine (
    .clk      (clk),
    .rst      (rst),
    .raw_next (raw_next),
    .mask_next(mask_d),
    .err_q    (rx_err)
  );

  assign raw_status = {unlock_q, framed_q};
endmodule

// File: rtl/rx_err_agg_chk.sv
module rx_err_agg_chk
  import rx_err_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  sf_strobe,
  input logic [NUM_FRAMED-1:0] sf_flags,
  input logic                  mask_we,
  input logic [NUM_SRC-1:0]    mask_wdata,
  input logic [NUM_SRC-1:0]    mask_q,
  input logic [NUM_SRC-1:0]    raw_status,
  input logic                  rx_err
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (raw_status == '0 && !rx_err && mask_q == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    sf_strobe |=> raw_status[NUM_FRAMED-1:0] == $past(sf_flags));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !sf_strobe |=> $stable(raw_status[NUM_FRAMED-1:0]));

  a_r5_mask_write: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> mask_q == $past(mask_wdata));

  a_r6_raise: assert property (@(posedge clk) disable iff (rst)
    ((raw_status & mask_q) != '0) |-> rx_err);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((raw_status & mask_q) == '0) |-> !rx_err);
endmodule

bind rx_err_agg rx_err_agg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sf_strobe (sf_strobe),
  .sf_flags  (sf_flags),
  .mask_we   (mask_we),
  .mask_wdata(mask_wdata),
  .mask_q    (mask_q),
  .raw_status(raw_status),
  .rx_err    (rx_err)
);

// File: tb/tb_rx_err_agg.sv
module tb_rx_err_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 6;
  localparam int NS = 7;

  logic          clk = 1'b0;
  logic          rst;
  logic          sf_strobe;
  logic [NF-1:0] sf_flags;
  logic          pll_unlock;
  logic          mask_we;
  logic [NS-1:0] mask_wdata;
  logic [NS-1:0] raw_status;
  logic          rx_err;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [NF-1:0] m_framed;
  logic          m_u1, m_u2;
  logic [NS-1:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_agg dut (
    .clk(clk), .rst(rst), .sf_strobe(sf_strobe), .sf_flags(sf_flags),
    .pll_unlock(pll_unlock), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .raw_status(raw_status), .rx_err(rx_err)
  );

  function automatic logic [NS-1:0] exp_raw();
    return {m_u2, m_framed};
  endfunction

  function automatic logic exp_err();
    return |(exp_raw() & m_mask);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      m_framed = '0; m_u1 = 1'b0; m_u2 = 1'b0; m_mask = '0;
    end else begin
      if (sf_strobe) m_framed = sf_flags;
      m_u2 = m_u1;
      m_u1 = pll_unlock;
      if (mask_we) m_mask = mask_wdata;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    sf_strobe = 1'b0; mask_we = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " raw"}, 32'(raw_status), 32'(exp_raw()));
    chk({tag, " err"}, 32'(rx_err), 32'(exp_err()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_framed = '0; m_u1 = 1'b0; m_u2 = 1'b0; m_mask = '0;
    rst = 1'b1; sf_strobe = 1'b1; sf_flags = '1; pll_unlock = 1'b0;
    mask_we = 1'b1; mask_wdata = '1;
    @(negedge clk);
    repeat (3) tick();
    chk("R1 reset raw", 32'(raw_status), 32'h0);
    chk("R1 reset err", 32'(rx_err), 32'h0);
    rst = 1'b0; mask_we = 1'b0; sf_strobe = 1'b1; sf_flags = 6'h3F;
    tick();
    chk("R2 all flags", 32'(raw_status), 32'h3F);
    chk("R1 default mask blocks", 32'(rx_err), 32'h0);
    idle();
    mask_we = 1'b1; mask_wdata = 7'h02;
    tick(); idle();
    chk("R5 parity enabled", 32'(rx_err), 32'h1);
    check_all("R6 parity");
    sf_strobe = 1'b1; sf_flags = 6'h00;
    tick(); idle();
    chk("R7 fall on clear", 32'(rx_err), 32'h0);
    check_all("R2 cleared");
    sf_strobe = 1'b1; sf_flags = 6'h01;
    tick(); idle();
    chk("R8 validity masked", 32'(rx_err), 32'h0);
    chk("R2 validity raw", 32'(raw_status), 32'h01);
    sf_flags = 6'h2A;
    tick(); tick();
    chk("R3 hold raw", 32'(raw_status), 32'h01);
    mask_we = 1'b1; mask_wdata = 7'h40; pll_unlock = 1'b1;
    tick(); idle();
    chk("R4 unlock after one edge", 32'(raw_status[6]), 32'h0);
    tick();
    chk("R4 unlock after two edges", 32'(raw_status[6]), 32'h1);
    chk("R6 unlock raises err", 32'(rx_err), 32'h1);
    pll_unlock = 1'b0;
    tick(); tick();
    chk("R7 unlock gone", 32'(rx_err), 32'h0);
    check_all("R4 unlock cleared");
    sf_strobe = 1'b1; sf_flags = 6'h08; mask_we = 1'b1; mask_wdata = 7'h08;
    tick(); idle();
    chk("R9 same edge rise", 32'(rx_err), 32'h1);
    sf_strobe = 1'b1; sf_flags = 6'h18; mask_we = 1'b1; mask_wdata = 7'h00;
    tick(); idle();
    chk("R9 same edge masked", 32'(rx_err), 32'h0);
    chk("R9 raw kept", 32'(raw_status), 32'h18);

    for (int i = 0; i < 4000; i++) begin
      sf_strobe  = ($urandom_range(3) == 0);
      sf_flags   = NF'($urandom) & NF'($urandom);
      mask_we    = ($urandom_range(7) == 0);
      mask_wdata = NS'($urandom);
      if ($urandom_range(15) == 0) pll_unlock = ~pll_unlock;
      tick();
      check_all("R2 R6 random");
    end
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule